// File: doc/BRIEF.md
# Bus-Driving Adder-Subtractor with Carry and Zero Flags

This block is the arithmetic unit of a small bus-oriented processor. It receives two operand words, one from the accumulator and one from a second working register, together with a subtract select. A ripple-carry chain forms the result combinationally, so the result follows the operands and the select with no clock edge in between.

The result reaches a shared data bus only while the output enable is high. At all other times the block releases every bus line to high impedance, so that other units can drive the bus.

Two status bits, carry and zero, are registered. They capture on a rising clock edge only when the bus is being driven at that edge, and they hold their value otherwise. Subtraction is formed as A plus the bitwise inverse of B plus one, with the select feeding the carry-in. The carry bit is the raw carry out of that chain: it is 1 when no borrow occurred.

Top module: `addsub_bus_unit`

## Requirements
- R1: With sub_en = 0 and drive_en = 1, res_bus equals (op_a + op_b) modulo 2^DATA_W.
- R2: With sub_en = 1 and drive_en = 1, res_bus equals (op_a - op_b) modulo 2^DATA_W, which is the two's complement difference.
- R3: The result on res_bus is combinational. A change of op_a, op_b or sub_en shows on the bus before the next rising clock edge.
- R4: With drive_en = 0, the block drives no line of res_bus, and every line is left at high impedance.
- R5: In add mode, a rising edge with drive_en = 1 loads carry_flag with bit DATA_W of the unsigned sum op_a + op_b.
- R6: In subtract mode, a rising edge with drive_en = 1 loads carry_flag with the carry out of op_a + ~op_b + 1. This is 1 exactly when op_a >= op_b, both read unsigned.
- R7: A rising edge with drive_en = 1 sets zero_flag to 1 if the DATA_W-bit result is all zeros, and clears it to 0 otherwise.
- R8: A rising edge with drive_en = 0 leaves both carry_flag and zero_flag unchanged, whatever the operands and sub_en are.
- R9: While rst_n is low (active-low, asynchronous), carry_flag and zero_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags capture on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_a | input | DATA_W | First operand, normally from the accumulator |
| op_b | input | DATA_W | Second operand |
| sub_en | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| drive_en | input | 1 | Active-high enable for the bus driver and for flag capture |
| res_bus | inout | DATA_W | Shared bus; carries the result or high impedance |
| carry_flag | output | 1 | Registered carry out of the last driven operation |
| zero_flag | output | 1 | Registered zero indication of the last driven operation |

## Verification
The bench builds the unit with DATA_W = 8 and ADDER_STYLE = 0, which gives the cell-by-cell ripple chain. This is the variant in which a carry fault at any single bit position can show up. At eight bits, random operands from 0 to 255 reach both carry outcomes in both modes, wrap-around results, and exact zero results such as 42 - 42. The bench checks the bus release by driving two complementary patterns onto the bus from the bench side while the enable is low.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   // Adder implementation variants
   localparam int STYLE_RIPPLE = 0;
   localparam int STYLE_INFER  = 1;

   typedef struct packed {
      logic carry;
      logic zero;
   } flag_t;

endpackage

// File: rtl/addsub_cell.sv
module addsub_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half;
   assign half = a_i ^ b_i;
   assign s_o  = half ^ c_i;
   assign c_o  = (a_i & b_i) | (c_i & half);
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain
   import addsub_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = STYLE_RIPPLE
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   assign b_eff = b_i ^ {DATA_W{sub_i}};

   if (ADDER_STYLE == STYLE_RIPPLE) begin : g_ripple
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic ci, co, so;
         if (i == 0) begin : g_first
            assign ci = sub_i;
         end else begin : g_next
            assign ci = g_bit[i-1].co;
         end
         addsub_cell u_cell (
            .a_i (a_i[i]),
            .b_i (b_eff[i]),
            .c_i (ci),
            .s_o (so),
            .c_o (co)
         );
         assign sum_o[i] = so;
      end
      assign cout_o = g_bit[MSB].co;
   end else begin : g_infer
      logic [DATA_W:0] wide;
      assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
      assign sum_o  = wide[MSB:0];
      assign cout_o = wide[DATA_W];
   end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
   import addsub_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cap_i,
   input  flag_t nxt_i,
   output flag_t cur_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_o <= '0;
      else if (cap_i)
         cur_o <= nxt_i;
   end

   // R8: flags hold when capture is off
   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(cur_o));

   // R9: reset leaves flags cleared
   assert_flags_reset_R9: assert property (@(posedge clk)
      !rst_n |=> (cur_o == '0 || $past(cap_i)) || rst_n);
endmodule

// File: rtl/addsub_bus_unit.sv
module addsub_bus_unit
   import addsub_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDER_STYLE = STYLE_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              sub_en,
   input  logic              drive_en,
   inout  wire  [DATA_W-1:0] res_bus,
   output logic              carry_flag,
   output logic              zero_flag
);
   localparam int RES_W = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("addsub_bus_unit: DATA_W must be at least 2");
   end
   if (ADDER_STYLE != STYLE_RIPPLE && ADDER_STYLE != STYLE_INFER) begin : g_bad_style
      $error("addsub_bus_unit: unknown ADDER_STYLE");
   end

   logic [DATA_W-1:0] sum_w;
   logic              cout_w;
   flag_t             flag_nxt, flag_cur;

   addsub_chain #(
      .DATA_W      (DATA_W),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_chain (
      .a_i    (op_a),
      .b_i    (op_b),
      .sub_i  (sub_en),
      .sum_o  (sum_w),
      .cout_o (cout_w)
   );

   assign flag_nxt.carry = cout_w;
   assign flag_nxt.zero  = ~|sum_w;

   addsub_flags u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (drive_en),
      .nxt_i (flag_nxt),
      .cur_o (flag_cur)
   );

   assign carry_flag = flag_cur.carry;
   assign zero_flag  = flag_cur.zero;

   // Tri-state bus driver
   assign res_bus = drive_en ? sum_w : {DATA_W{1'bz}};

   // R1: add path result
   assert_add_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_en |-> ({cout_w, sum_w} == RES_W'({1'b0, op_a} + {1'b0, op_b})));

   // R2: subtract path result
   assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_en |-> (sum_w == DATA_W'(op_a - op_b)));

   // R5: carry captured from chain
   assert_carry_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |=> (carry_flag == $past(cout_w)));

   // R6: subtract carry means no borrow
   assert_sub_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && sub_en) |=> (carry_flag == ($past(op_a) >= $past(op_b))));

   // R7: zero flag tracks driven result
   assert_zero_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |=> (zero_flag == ($past(sum_w) == '0)));
endmodule

// File: tb/tb_addsub_bus_unit.sv
`timescale 1ns/1ps
module tb_addsub_bus_unit;
   localparam int W = 8;

   typedef struct packed {
      logic [W-1:0] res;
      logic         cf;
      logic         zf;
      logic [2:0]   req;  // 1=R1 add, 2=R2 sub
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         sub_en = 1'b0, drive_en = 1'b0;
   logic         carry_flag, zero_flag;
   wire  [W-1:0] bus_w;
   logic         tb_drv = 1'b0;
   logic [W-1:0] tb_val = '0;

   assign bus_w = tb_drv ? tb_val : {W{1'bz}};

   int n_run = 0, n_fail = 0;
   exp_t sb_q[$];
   bit   done = 0;

   always #4 clk = ~clk;

   addsub_bus_unit #(.DATA_W(W), .ADDER_STYLE(0)) dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .sub_en(sub_en), .drive_en(drive_en), .res_bus(bus_w),
      .carry_flag(carry_flag), .zero_flag(zero_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      logic [W:0] t;
      exp_t e;
      t = s ? ({1'b0, a} + {1'b0, ~b} + 9'd1) : ({1'b0, a} + {1'b0, b});
      e.res = t[W-1:0];
      e.cf  = t[W];
      e.zf  = (t[W-1:0] == '0);
      e.req = s ? 3'd2 : 3'd1;
      return e;
   endfunction

   // Driver: set inputs at falling edge, push expectation
   task automatic drive_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      @(negedge clk);
      op_a = a; op_b = b; sub_en = s; drive_en = 1'b1;
      sb_q.push_back(model(a, b, s));
   endtask

   // Monitor: after each rising edge, compare bus and captured flags
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            string rq;
            e = sb_q.pop_front();
            rq = (e.req == 3'd2) ? "R2" : "R1";
            check(bus_w == e.res, rq, bus_w, e.res);
            check(carry_flag == e.cf, (e.req == 3'd2) ? "R6" : "R5", carry_flag, e.cf);
            check(zero_flag == e.zf, "R7", zero_flag, e.zf);
         end
      end
   end

   initial begin
      #(8 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check(carry_flag == 1'b0, "R9", carry_flag, 0);
      check(zero_flag == 1'b0, "R9", zero_flag, 0);
      rst_n = 1'b1;

      // Directed corner cases
      drive_op(8'd42, 8'd42, 1'b1);   // zero result, no borrow
      drive_op(8'd60, 8'hBA, 1'b0);   // 60 + (-70) = -10
      drive_op(8'd9, 8'd11, 1'b1);    // -2, borrow
      drive_op(8'hFF, 8'h01, 1'b0);   // wrap to zero with carry
      drive_op(8'd0, 8'd0, 1'b0);     // zero, no carry
      drive_op(8'd0, 8'd0, 1'b1);     // 0-0: carry 1
      drive_op(8'h80, 8'h80, 1'b0);

      // Random add, sub, mixed
      for (int k = 0; k < 50; k++) drive_op(W'($urandom_range(0, 255)), W'($urandom_range(0, 255)), 1'b0);
      for (int k = 0; k < 50; k++) drive_op(W'($urandom_range(0, 255)), W'($urandom_range(0, 255)), 1'b1);
      for (int k = 0; k < 50; k++) drive_op(W'($urandom_range(0, 255)), W'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      @(posedge clk); #2;

      // R3: result follows operands without a clock edge
      @(negedge clk);
      op_a = 8'd17; op_b = 8'd5; sub_en = 1'b0; drive_en = 1'b1;
      #1 check(bus_w == 8'd22, "R3", bus_w, 22);
      sub_en = 1'b1;
      #1 check(bus_w == 8'd12, "R3", bus_w, 12);
      op_b = 8'd17;
      #1 check(bus_w == 8'd0, "R3", bus_w, 0);
      // edge captures 17-17: cf=1 zf=1
      @(posedge clk); #1;
      check(carry_flag && zero_flag, "R7", {carry_flag, zero_flag}, 3);

      // R8: enable low, operands would change both flags
      @(negedge clk);
      drive_en = 1'b0; op_a = 8'd3; op_b = 8'd200; sub_en = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(carry_flag == 1'b1, "R8", carry_flag, 1);
      check(zero_flag == 1'b1, "R8", zero_flag, 1);

      // R4: bus released; bench patterns read back unchanged
      tb_drv = 1'b1; tb_val = 8'hA5;
      #1 check(bus_w == 8'hA5, "R4", bus_w, 8'hA5);
      tb_val = 8'h5A;
      #1 check(bus_w == 8'h5A, "R4", bus_w, 8'h5A);
      tb_drv = 1'b0;

      // R9: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(carry_flag == 1'b0, "R9", carry_flag, 0);
      check(zero_flag == 1'b0, "R9", zero_flag, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule